// File: doc/BRIEF.md
# Buffered Program Controller for a Flash Array Model

This block is the device-side path that programs a run of up to 32 words into a flash array model in one internally timed operation. The host first writes a setup command and reads status bit 7 to see whether the write buffer was granted. If bit 7 is 0, the host writes the setup command again until the grant comes. Once the buffer is granted, the host writes a word count inside the buffer's 32-word aligned window. It then writes that many data words into the window and finishes with a confirm command.

After the confirm, the controller runs a program phase of fixed length. At the end of the phase it merges every buffered word into the array. Programming can only clear bits, so the stored value becomes the old value ANDed with the new data. A fault in the load sequence aborts the sequence. A supply fault or a locked target refuses the program without touching the array. A word that would need a bit raised from 0 to 1 is reported as a program failure.

Host writes use a valid/ready handshake. A write is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. While the program phase runs, `wr_ready` is low, so the host must hold its write, with address and data unchanged, until `wr_ready` returns. The status word and the array read port are plain outputs that can be sampled at any time.

Top module: `wbp_ctrl`

## Requirements
- R1: After reset, `status` is 0x80, `wr_ready` is 1, and every array word reads 0xFFFF.
- R2: Writing data 0x00E8 while idle or while the count is awaited is a setup. With `buf_busy`=1 it sets status bit 7 to 0 and leaves the controller idle, so a following non-command write has no effect. With `buf_busy`=0 it sets bit 7 to 1 and arms the buffer for the 32-word aligned window that holds the write address. A repeated setup is accepted in the same way.
- R3: The first write after a granted setup is the count. Its value V is the word count minus one (0 to 31 means 1 to 32 words). It must be written inside the window, and exactly V+1 data writes follow.
- R4: A count write whose value is 32 or more, or whose address is outside the window, aborts the sequence. The abort sets status bits 5 and 4 (status becomes 0xB0) and returns the controller to idle.
- R5: A data write whose address is outside the window aborts the sequence in the same way as R4.
- R6: After the last data word, a write of 0x00D0 confirms the program. Any other data written at that point aborts the sequence as in R4, and the array is left unchanged.
- R7: After the confirm edge, `wr_ready` and status bit 7 stay 0 for PROG_BASE + N clock cycles, where N is the word count. Both then return to 1.
- R8: At the end of the phase, each buffered address holds its old value AND its data word. No other array word changes, and the array does not change at any other time.
- R9: If any buffered data word has a 1 in a bit where the target array word holds a 0, status bit 4 is set at the end of the phase and bit 5 stays 0.
- R10: A confirm while `vpp_ok`=0 sets status bit 3 and nothing else. No program phase starts and the array is unchanged. The supply check takes priority over the lock check.
- R11: A confirm with `vpp_ok`=1 and `blk_locked`=1 sets status bit 1. No program phase starts and the array is unchanged.
- R12: Writing 0x0050 while idle clears status bits 5, 4, 3 and 1.
- R13: A write offered while `wr_ready` is 0 is not taken. It is taken on the first edge after `wr_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Controller can take a write (low during the program phase) |
| wr_addr | input | AW (8) | Write word address |
| wr_data | input | DW (16) | Write data or command |
| buf_busy | input | 1 | Forces a setup to report the buffer as unavailable |
| vpp_ok | input | 1 | Program supply is within range |
| blk_locked | input | 1 | Target block is locked |
| rd_addr | input | AW (8) | Array read address |
| rd_data | output | DW (16) | Array word at `rd_addr` (combinational) |
| status | output | 8 | Bit 7 ready, bit 5 sequence error, bit 4 program fail, bit 3 supply fault, bit 1 lock; other bits 0 |

## Verification
A write taken on an edge changes `status` and `wr_ready` right after that same edge. A program phase ends PROG_BASE + N edges after the confirm edge, and the merged array words are visible on `rd_data` from that point on. The bench keeps a behavioural model that it advances on the same edges. It compares status, ready and the word read back 2 ns after every falling edge, so each result is checked in the first half-cycle in which it is due. Phase lengths are measured by counting the falling edges that show `wr_ready` low, and these counts are compared with PROG_BASE + N.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_PROG
  } wbp_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  localparam int SR_READY  = 7;
  localparam int SR_SEQ    = 5;
  localparam int SR_FAIL   = 4;
  localparam int SR_SUPPLY = 3;
  localparam int SR_LOCK   = 1;
endpackage

// File: rtl/wbp_buffer.sv
module wbp_buffer #(
  parameter int DW    = 16,
  parameter int WORDS = 32,
  parameter int OFFW  = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       we,
  input  logic [OFFW-1:0]            off,
  input  logic [DW-1:0]              wdata,
  output logic [WORDS-1:0][DW-1:0]   words,
  output logic [WORDS-1:0]           mask
);
  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
        mask[g]  <= 1'b0;
      end else if (clr) begin
        mask[g]  <= 1'b0;
      end else if (we && off == OFFW'(g)) begin
        words[g] <= wdata;
        mask[g]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbp_array.sv
module wbp_array #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int WORDS = 32,
  parameter int OFFW  = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [AW-OFFW-1:0]        base_hi,
  input  logic [WORDS-1:0][DW-1:0]  words,
  input  logic [WORDS-1:0]          mask,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic                      verify_fail
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < WORDS; i++) begin
        if (mask[i]) mem[{base_hi, OFFW'(i)}] <= mem[{base_hi, OFFW'(i)}] & words[i];
      end
    end
  end

  // A 1 requested over a stored 0 cannot be produced by clearing bits.
  always_comb begin
    verify_fail = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      if (mask[i] && |(words[i] & ~mem[{base_hi, OFFW'(i)}])) verify_fail = 1'b1;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/wbp_seq.sv
module wbp_seq
  import wbp_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int WORDS     = 32,
  parameter int OFFW      = $clog2(WORDS),
  parameter int PROG_BASE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               buf_busy,
  input  logic               vpp_ok,
  input  logic               blk_locked,
  input  logic               verify_fail,
  output logic               wr_ready,
  output logic               buf_clr,
  output logic               buf_we,
  output logic [OFFW-1:0]    buf_off,
  output logic               commit,
  output logic [AW-OFFW-1:0] base_hi,
  output logic [7:0]         status
);
  localparam int CW = $clog2(WORDS + 1);
  localparam int PW = $clog2(PROG_BASE + WORDS + 1);

  wbp_state_e  state;
  logic [CW-1:0] nwords, left;
  logic [PW-1:0] pcnt;
  logic sr_rdy, sr_seq, sr_fail, sr_sup, sr_lck;

  logic is_setup, is_confirm, is_clear, win_hit, cnt_ok, setup_slot;

  assign is_setup   = wr_data == DW'(CMD_SETUP);
  assign is_confirm = wr_data == DW'(CMD_CONFIRM);
  assign is_clear   = wr_data == DW'(CMD_CLEAR);
  assign win_hit    = wr_addr[AW-1:OFFW] == base_hi;
  assign cnt_ok     = wr_data[DW-1:OFFW] == '0;
  assign setup_slot = (state == ST_IDLE) || (state == ST_COUNT);

  assign wr_ready = state != ST_PROG;
  assign buf_clr  = fire && setup_slot && is_setup && !buf_busy;
  assign buf_we   = fire && (state == ST_DATA) && win_hit;
  assign buf_off  = wr_addr[OFFW-1:0];
  assign commit   = (state == ST_PROG) && (pcnt == PW'(1));

  assign status = {sr_rdy, 1'b0, sr_seq, sr_fail, sr_sup, 1'b0, sr_lck, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nwords  <= '0;
      left    <= '0;
      pcnt    <= '0;
      base_hi <= '0;
      sr_rdy  <= 1'b1;
      sr_seq  <= 1'b0;
      sr_fail <= 1'b0;
      sr_sup  <= 1'b0;
      sr_lck  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_COUNT: begin
          if (fire) begin
            if (is_setup) begin
              sr_rdy <= !buf_busy;
              if (!buf_busy) begin
                state   <= ST_COUNT;
                base_hi <= wr_addr[AW-1:OFFW];
              end else begin
                state   <= ST_IDLE;
              end
            end else if (state == ST_IDLE) begin
              if (is_clear) begin
                sr_seq  <= 1'b0;
                sr_fail <= 1'b0;
                sr_sup  <= 1'b0;
                sr_lck  <= 1'b0;
              end
            end else if (cnt_ok && win_hit) begin
              nwords <= CW'(wr_data[OFFW-1:0]) + CW'(1);
              left   <= CW'(wr_data[OFFW-1:0]) + CW'(1);
              state  <= ST_DATA;
            end else begin
              sr_seq  <= 1'b1;
              sr_fail <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (fire) begin
            if (win_hit) begin
              left <= left - CW'(1);
              if (left == CW'(1)) state <= ST_CONFIRM;
            end else begin
              sr_seq  <= 1'b1;
              sr_fail <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_CONFIRM: begin
          if (fire) begin
            if (!is_confirm) begin
              sr_seq  <= 1'b1;
              sr_fail <= 1'b1;
              state   <= ST_IDLE;
            end else if (!vpp_ok) begin
              sr_sup <= 1'b1;
              state  <= ST_IDLE;
            end else if (blk_locked) begin
              sr_lck <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              pcnt   <= PW'(PROG_BASE) + PW'(nwords);
              sr_rdy <= 1'b0;
              state  <= ST_PROG;
            end
          end
        end
        ST_PROG: begin
          pcnt <= pcnt - PW'(1);
          if (pcnt == PW'(1)) begin
            state  <= ST_IDLE;
            sr_rdy <= 1'b1;
            if (verify_fail) sr_fail <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbp_ctrl.sv
module wbp_ctrl #(
  parameter int DW        = 16,
  parameter int AW        = 8,
  parameter int WORDS     = 32,
  parameter int PROG_BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          buf_busy,
  input  logic          vpp_ok,
  input  logic          blk_locked,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);
  localparam int OFFW = $clog2(WORDS);

  logic                      fire, buf_clr, buf_we, commit, verify_fail;
  logic [OFFW-1:0]           buf_off;
  logic [AW-OFFW-1:0]        base_hi;
  logic [WORDS-1:0][DW-1:0]  words;
  logic [WORDS-1:0]          mask;

  assign fire = wr_valid && wr_ready;

  wbp_seq #(.DW(DW), .AW(AW), .WORDS(WORDS), .OFFW(OFFW), .PROG_BASE(PROG_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_busy(buf_busy), .vpp_ok(vpp_ok), .blk_locked(blk_locked),
    .verify_fail(verify_fail), .wr_ready(wr_ready), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_off(buf_off), .commit(commit), .base_hi(base_hi),
    .status(status)
  );

  wbp_buffer #(.DW(DW), .WORDS(WORDS), .OFFW(OFFW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .off(buf_off),
    .wdata(wr_data), .words(words), .mask(mask)
  );

  wbp_array #(.DW(DW), .AW(AW), .WORDS(WORDS), .OFFW(OFFW)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .base_hi(base_hi),
    .words(words), .mask(mask), .rd_addr(rd_addr), .rd_data(rd_data),
    .verify_fail(verify_fail)
  );
endmodule

// File: rtl/wbp_ctrl_chk.sv
module wbp_ctrl_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_data,
  input logic          vpp_ok,
  input logic          blk_locked,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic [7:0]    status
);
  assert_phase_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !status[7]);

  assert_phase_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_ready) |-> $past(wr_valid && wr_data == DW'(8'hD0)));

  assert_abort_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> status[4]);

  assert_supply_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(wr_valid && wr_ready && wr_data == DW'(8'hD0) && !vpp_ok));

  assert_lock_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(wr_valid && wr_ready && wr_data == DW'(8'hD0) && vpp_ok && blk_locked));

  assert_array_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_ready) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind wbp_ctrl wbp_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .vpp_ok(vpp_ok), .blk_locked(blk_locked),
  .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
);

// File: tb/sim_wbp_ctrl.sv
`timescale 1ns/1ps
module sim_wbp_ctrl;
  localparam int PB = 8;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, buf_busy = 0, vpp_ok = 1, blk_locked = 0;
  logic wr_ready;
  logic [7:0] wr_addr = 0, rd_addr = 0, status;
  logic [15:0] wr_data = 0, rd_data;

  int checks = 0, failures = 0, cyc = 0, dummy, n;
  string cur_req = "R1";

  always #4 clk = ~clk;

  wbp_ctrl #(.DW(16), .AW(8), .WORDS(32), .PROG_BASE(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .buf_busy(buf_busy), .vpp_ok(vpp_ok),
    .blk_locked(blk_locked), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_state, m_base, m_left, m_n, m_pc;
  bit m7, m5, m4, m3, m1;
  logic [15:0] m_mem [256];
  logic [15:0] m_buf [32];
  bit m_mask [32];

  function automatic logic [7:0] m_status();
    return {m7, 1'b0, m5, m4, m3, 1'b0, m1, 1'b0};
  endfunction

  always @(posedge clk) begin
    int a, d;
    if (!rst_n) begin
      m_state = 0; m7 = 1; m5 = 0; m4 = 0; m3 = 0; m1 = 0;
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else if (m_state == 4) begin
      m_pc--;
      if (m_pc == 0) begin
        for (int i = 0; i < 32; i++) if (m_mask[i]) begin
          if ((m_buf[i] & ~m_mem[m_base*32+i]) != 0) m4 = 1;
          m_mem[m_base*32+i] = m_mem[m_base*32+i] & m_buf[i];
        end
        m_state = 0; m7 = 1;
      end
    end else if (wr_valid) begin
      a = wr_addr; d = wr_data;
      if ((m_state == 0 || m_state == 1) && d == 'hE8) begin
        m7 = !buf_busy;
        if (!buf_busy) begin
          m_state = 1; m_base = a / 32;
          foreach (m_mask[i]) m_mask[i] = 0;
        end else m_state = 0;
      end else if (m_state == 0) begin
        if (d == 'h50) begin m5 = 0; m4 = 0; m3 = 0; m1 = 0; end
      end else if (m_state == 1) begin
        if (d < 32 && a / 32 == m_base) begin m_n = d + 1; m_left = m_n; m_state = 2; end
        else begin m5 = 1; m4 = 1; m_state = 0; end
      end else if (m_state == 2) begin
        if (a / 32 == m_base) begin
          m_buf[a % 32] = wr_data; m_mask[a % 32] = 1; m_left--;
          if (m_left == 0) m_state = 3;
        end else begin m5 = 1; m4 = 1; m_state = 0; end
      end else begin
        if (d != 'hD0) begin m5 = 1; m4 = 1; m_state = 0; end
        else if (!vpp_ok) begin m3 = 1; m_state = 0; end
        else if (blk_locked) begin m1 = 1; m_state = 0; end
        else begin m_pc = PB + m_n; m_state = 4; m7 = 0; end
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(status == m_status(), cur_req, "status vs model", status, m_status());
      chk(wr_ready == (m_state != 4), cur_req, "wr_ready vs model", wr_ready, m_state != 4);
      chk(rd_data == m_mem[rd_addr], cur_req, "rd_data vs model", rd_data, m_mem[rd_addr]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R13 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input int a, input int d, output int waited);
    @(negedge clk);
    wr_valid = 1; wr_addr = 8'(a); wr_data = 16'(d);
    waited = 0;
    while (!wr_ready) begin waited++; @(negedge clk); end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = 8'(a);
    #1;
    chk(rd_data == 16'(exp), req, "array word", rd_data, exp);
  endtask

  task automatic st_chk(input int exp, input string req);
    #1;
    chk(status == 8'(exp), req, "status", status, exp);
  endtask

  task automatic phase_len(output int len);
    len = 0;
    while (!wr_ready) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    chk(status == 8'h80, "R1", "reset status", status, 8'h80);
    chk(wr_ready == 1'b1, "R1", "reset ready", wr_ready, 1);
    rd_chk(8'h40, 16'hFFFF, "R1");

    // R2 refused setup, then retry
    cur_req = "R2";
    buf_busy = 1;
    wr(8'h40, 'hE8, dummy); st_chk(8'h00, "R2");
    wr(8'h40, 'h03, dummy); st_chk(8'h00, "R2");
    buf_busy = 0;
    wr(8'h40, 'hE8, dummy); st_chk(8'h80, "R2");
    wr(8'h41, 'hE8, dummy); st_chk(8'h80, "R2");

    // R3/R7/R8: four words, program phase length
    cur_req = "R3";
    wr(8'h42, 3, dummy);
    wr(8'h40, 'hFF00, dummy); wr(8'h41, 'h0F0F, dummy);
    wr(8'h42, 'h1234, dummy); wr(8'h43, 'hAAAA, dummy);
    cur_req = "R7";
    wr(8'h40, 'hD0, dummy);
    phase_len(n);
    chk(n == PB + 4, "R7", "phase length 4 words", n, PB + 4);
    st_chk(8'h80, "R9");
    cur_req = "R8";
    rd_chk(8'h41, 16'h0F0F, "R8");
    rd_chk(8'h43, 16'hAAAA, "R8");
    rd_chk(8'h44, 16'hFFFF, "R8");

    // R3 full buffer of 32 words
    cur_req = "R3";
    wr(8'h80, 'hE8, dummy); wr(8'h9F, 31, dummy);
    for (int i = 0; i < 32; i++) wr(8'h80 + i, 16'hFFFF ^ (16'h1 << (i % 16)), dummy);
    wr(8'h80, 'hD0, dummy);
    phase_len(n);
    chk(n == PB + 32, "R7", "phase length 32 words", n, PB + 32);
    rd_chk(8'h85, 16'hFFDF, "R3");

    // R9 verify fail, single word (count 0)
    cur_req = "R9";
    wr(8'h40, 'hE8, dummy); wr(8'h40, 0, dummy); wr(8'h40, 'h00FF, dummy);
    wr(8'h40, 'hD0, dummy); phase_len(n);
    st_chk(8'h90, "R9");
    rd_chk(8'h40, 16'h0000, "R8");
    cur_req = "R12";
    wr(0, 'h50, dummy); st_chk(8'h80, "R12");

    // R4 count too large, count outside window
    cur_req = "R4";
    wr(8'h40, 'hE8, dummy); wr(8'h40, 32, dummy); st_chk(8'hB0, "R4");
    wr(0, 'h50, dummy);
    wr(8'h40, 'hE8, dummy); wr(8'h60, 1, dummy); st_chk(8'hB0, "R4");
    wr(0, 'h50, dummy);

    // R5 data outside window
    cur_req = "R5";
    wr(8'h40, 'hE8, dummy); wr(8'h40, 1, dummy); wr(8'h44, 'h0000, dummy);
    wr(8'h20, 'h0000, dummy); st_chk(8'hB0, "R5");
    rd_chk(8'h44, 16'hFFFF, "R5");
    wr(0, 'h50, dummy);

    // R6 wrong confirm
    cur_req = "R6";
    wr(8'h40, 'hE8, dummy); wr(8'h40, 0, dummy); wr(8'h45, 'h0000, dummy);
    wr(8'h40, 'hFF, dummy); st_chk(8'hB0, "R6");
    rd_chk(8'h45, 16'hFFFF, "R6");
    wr(0, 'h50, dummy);

    // R10 supply fault, priority over lock
    cur_req = "R10";
    vpp_ok = 0; blk_locked = 1;
    wr(8'h40, 'hE8, dummy); wr(8'h40, 0, dummy); wr(8'h46, 'h0000, dummy);
    wr(8'h40, 'hD0, dummy); st_chk(8'h88, "R10");
    chk(wr_ready == 1'b1, "R10", "no phase started", wr_ready, 1);
    rd_chk(8'h46, 16'hFFFF, "R10");
    vpp_ok = 1;
    wr(0, 'h50, dummy);

    // R11 locked
    cur_req = "R11";
    wr(8'h40, 'hE8, dummy); wr(8'h40, 0, dummy); wr(8'h46, 'h0000, dummy);
    wr(8'h40, 'hD0, dummy); st_chk(8'h82, "R11");
    rd_chk(8'h46, 16'hFFFF, "R11");
    blk_locked = 0;
    wr(0, 'h50, dummy); st_chk(8'h80, "R12");

    // R13 write held during the program phase
    cur_req = "R13";
    wr(8'h60, 'hE8, dummy); wr(8'h60, 0, dummy); wr(8'h60, 'h0001, dummy);
    wr(8'h60, 'hD0, dummy);
    buf_busy = 1;
    wr(8'h60, 'hE8, n);
    chk(n == PB, "R13", "cycles held", n, PB);
    st_chk(8'h00, "R13");
    rd_chk(8'h60, 16'h0001, "R8");
    buf_busy = 0;
    wr(8'h60, 'hE8, dummy); st_chk(8'h80, "R2");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule